// File: doc/BRIEF.md
# Fiducial Overlay Placement Controller

This block holds the single 32-bit control word that governs a small set of synthetic marker layers drawn over a video frame. The host writes the word through a plain write-enable CSR port and reads it back at any time. From it the controller drives one enable bit per layer and an X/Y offset pair per layer to a downstream layer mixer. The controller never renders pixels. It only decides which layers are visible and where each one sits.

A placement run gives every layer a pseudo-random top-left corner that lies fully inside the frame and does not overlap any layer placed earlier in the same run. A run starts when the host requests a mix, or on the controller's own initiative whenever the visible set is empty. That covers the state after reset and a pick-and-clear loop in which the host clears one show bit per pick. At the end of a run the controller writes back the mask of placed layers and the layer count, and it clears the request. The host therefore only has to clear bits to keep the loop going.

The state machine has six states. IDLE accepts host writes and starts a run (IDLE→DRAW) when the request bit is set or the show mask is zero. DRAW latches a candidate from the random source (DRAW→CHECK). CHECK compares the candidate with one earlier slot per clock. It goes to COMMIT when every earlier slot has been compared. It goes back to DRAW on a hit while attempts remain, and to NEXT on a hit at the final attempt. COMMIT stores the position (COMMIT→NEXT). NEXT moves to the next layer (NEXT→DRAW), or after the last layer goes to DONE. DONE writes back the register fields (DONE→IDLE).

Top module: `fid_place_ctrl`

## Requirements
- R1: While reset is asserted the read word is 0x0000_0000, all layer enables are 0 and all X and Y offsets are 0.
- R2: The read word carries the busy flag in bit 31, zeros in bits 30:24, the show mask in bits 23:16, the layer count in bits 15:8 and the mix request in bits 7:0 (0 or 1). Host data written to bits 15:8 has no effect.
- R3: An idle write whose low byte is exactly 0x01 sets the mix request. The busy flag reads 1 from the second clock after that write. A low byte other than 0x01 stores a request of 0 and starts nothing.
- R4: Whenever the controller is idle and the show mask is zero, busy reads 1 one clock later and a run starts. This covers the first clock after reset and a write that clears the last show bit. The mix request reads 1 for the whole run.
- R5: An idle write with a nonzero mask and no request only changes which layers are enabled. The enables equal the mask from the next clock, busy stays 0, and no offset changes.
- R6: When a run ends, busy reads 0, the show mask equals the set of layers placed (0x1F for the default five layers), the count field equals the number of layers minus one, and the mix request reads 0.
- R7: Every placed layer lies inside the frame (0 ≤ X ≤ width − marker size, 0 ≤ Y ≤ height − marker size). No two placed layers overlap: for each pair, |ΔX| ≥ marker size or |ΔY| ≥ marker size.
- R8: Host writes made while busy reads 1 change nothing. The show mask read during the run keeps its pre-run value, and the value written back at the end does not depend on such writes.
- R9: All layer enables are 0 while busy reads 1. Offsets change only while busy reads 1.
- R10: A layer that fails the overlap test on 64 successive candidates is skipped. A run therefore lasts at most layers × (64 × (layers + 2) + 3) + 4 clocks.
- R11: Show-mask bits at or above the layer count are dropped on write and read back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr_en | input | 1 | Host write strobe for the control word |
| csr_wr_data | input | 32 | Host write data |
| csr_rd_data | output | 32 | Control word read-back, including busy |
| layer_en_o | output | NUM_LAYERS | Per-layer visible enable to the mixer |
| layer_x_o | output | NUM_LAYERS × clog2(FRAME_W) | Packed per-layer X offsets, layer 0 in the low bits |
| layer_y_o | output | NUM_LAYERS × clog2(FRAME_H) | Packed per-layer Y offsets, layer 0 in the low bits |

## Verification
A host write is visible on the read word and the enables one clock after the capturing edge. A start condition (request set, or mask empty) shows as busy one clock after the field carrying it holds that value. So a request write makes busy rise two clocks after its edge, and an empty mask makes busy rise one clock after it becomes empty. The end of a run depends on the random draws, so the behavioural model in the bench releases its busy expectation on the clock where busy falls. At that clock it checks the written-back fields, the frame bounds and the pairwise separation. It also checks that the run stayed within the R10 clock bound. On every other clock the bench compares the whole read word, the enables and the frozen offsets with the model, sampling on the falling edge.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DRAW,
        S_CHECK,
        S_COMMIT,
        S_NEXT,
        S_DONE
    } fpc_state_t;

    localparam int BUSY_BIT  = 31;
    localparam int SHOW_LSB  = 16;
    localparam int CNT_LSB   = 8;
    localparam int MIX_LSB   = 0;
    localparam int FIELD_W   = 8;
    localparam int RAND_W    = 16;

endpackage

// File: rtl/fpc_lfsr.sv
module fpc_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] rnd_o
);
    logic [15:0] q;
    logic        fb;

    // taps 16,14,13,11: maximal length
    assign fb = q[15] ^ q[13] ^ q[12] ^ q[10];

    always_ff @(posedge clk) begin
        if (!rst_n) q <= SEED;
        else        q <= {q[14:0], fb};
    end

    assign rnd_o = q;
endmodule

// File: rtl/fpc_scale.sv
module fpc_scale #(
    parameter int IN_W  = 16,
    parameter int SPAN  = 897,
    parameter int OUT_W = 10
) (
    input  logic [IN_W-1:0]  raw_i,
    output logic [OUT_W-1:0] val_o
);
    localparam int SW = $clog2(SPAN + 1);
    localparam int PW = IN_W + SW;

    logic [PW-1:0] prod;

    // raw * SPAN / 2^IN_W lies in [0, SPAN-1]
    assign prod  = PW'(raw_i) * PW'(SPAN);
    assign val_o = OUT_W'(prod >> IN_W);
endmodule

// File: rtl/fpc_rect_hit.sv
module fpc_rect_hit #(
    parameter int CW   = 10,
    parameter int SIZE = 64
) (
    input  logic [CW-1:0] ax_i,
    input  logic [CW-1:0] ay_i,
    input  logic [CW-1:0] bx_i,
    input  logic [CW-1:0] by_i,
    output logic          hit_o
);
    logic [CW:0] ax, ay, bx, by, sz;
    logic        x_ovl, y_ovl;

    assign ax = {1'b0, ax_i};
    assign ay = {1'b0, ay_i};
    assign bx = {1'b0, bx_i};
    assign by = {1'b0, by_i};
    assign sz = (CW+1)'(SIZE);

    assign x_ovl = (ax < bx + sz) && (bx < ax + sz);
    assign y_ovl = (ay < by + sz) && (by < ay + sz);
    assign hit_o = x_ovl && y_ovl;
endmodule

// File: rtl/fid_place_ctrl.sv
module fid_place_ctrl
    import fpc_pkg::*;
#(
    parameter int NUM_LAYERS = 5,
    parameter int MARK_SZ    = 64,
    parameter int FRAME_W    = 960,
    parameter int FRAME_H    = 540,
    parameter int MAX_TRIES  = 64,
    localparam int XW        = $clog2(FRAME_W),
    localparam int YW        = $clog2(FRAME_H)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       csr_wr_en,
    input  logic [31:0]                csr_wr_data,
    output logic [31:0]                csr_rd_data,
    output logic [NUM_LAYERS-1:0]      layer_en_o,
    output logic [NUM_LAYERS*XW-1:0]   layer_x_o,
    output logic [NUM_LAYERS*YW-1:0]   layer_y_o
);
    localparam int LW     = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1;
    localparam int TW     = $clog2(MAX_TRIES + 1);
    localparam int CW     = (XW > YW) ? XW : YW;
    localparam int SPAN_X = FRAME_W - MARK_SZ + 1;
    localparam int SPAN_Y = FRAME_H - MARK_SZ + 1;
    localparam logic [FIELD_W-1:0] LAYER_MASK = FIELD_W'((9'd1 << NUM_LAYERS) - 9'd1);
    localparam logic [LW-1:0]      LAST_LAYER = LW'(NUM_LAYERS - 1);

    fpc_state_t state_q, state_d;

    logic [FIELD_W-1:0]    show_q;
    logic [FIELD_W-1:0]    cnt_q;
    logic                  mix_q;
    logic [NUM_LAYERS-1:0] placed_q;
    logic [LW-1:0]         lay_q;
    logic [LW-1:0]         cmp_q;
    logic [TW-1:0]         tries_q;
    logic [XW-1:0]         cand_x_q;
    logic [YW-1:0]         cand_y_q;
    logic [XW-1:0]         pos_x [NUM_LAYERS];
    logic [YW-1:0]         pos_y [NUM_LAYERS];

    logic [RAND_W-1:0] rnd;
    logic [XW-1:0]     draw_x;
    logic [YW-1:0]     draw_y;
    logic              slot_hit;
    logic              start_run;
    logic              cmp_done;
    logic              reject;
    logic              busy;

    // ---------------- random source and candidate reduction ----------------
    fpc_lfsr #(.SEED(16'hACE1)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd_o (rnd)
    );

    fpc_scale #(.IN_W(RAND_W), .SPAN(SPAN_X), .OUT_W(XW)) u_scale_x (
        .raw_i (rnd),
        .val_o (draw_x)
    );

    fpc_scale #(.IN_W(RAND_W), .SPAN(SPAN_Y), .OUT_W(YW)) u_scale_y (
        .raw_i ({rnd[7:0], rnd[15:8]}),
        .val_o (draw_y)
    );

    // ---------------- overlap test against one earlier slot ----------------
    fpc_rect_hit #(.CW(CW), .SIZE(MARK_SZ)) u_hit (
        .ax_i  (CW'(cand_x_q)),
        .ay_i  (CW'(cand_y_q)),
        .bx_i  (CW'(pos_x[cmp_q])),
        .by_i  (CW'(pos_y[cmp_q])),
        .hit_o (slot_hit)
    );

    assign start_run = mix_q || (show_q == '0);
    assign cmp_done  = (cmp_q == lay_q);
    assign reject    = placed_q[cmp_q] && slot_hit;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_run) state_d = S_DRAW;
            S_DRAW:   state_d = S_CHECK;
            S_CHECK: begin
                if (cmp_done)
                    state_d = S_COMMIT;
                else if (reject)
                    state_d = (tries_q == TW'(MAX_TRIES - 1)) ? S_NEXT : S_DRAW;
            end
            S_COMMIT: state_d = S_NEXT;
            S_NEXT:   state_d = (lay_q == LAST_LAYER) ? S_DONE : S_DRAW;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            show_q   <= '0;
            cnt_q    <= '0;
            mix_q    <= 1'b0;
            placed_q <= '0;
            lay_q    <= '0;
            cmp_q    <= '0;
            tries_q  <= '0;
            cand_x_q <= '0;
            cand_y_q <= '0;
            for (int i = 0; i < NUM_LAYERS; i++) begin
                pos_x[i] <= '0;
                pos_y[i] <= '0;
            end
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (csr_wr_en) begin
                        show_q <= csr_wr_data[SHOW_LSB +: FIELD_W] & LAYER_MASK;
                        mix_q  <= (csr_wr_data[MIX_LSB +: FIELD_W] == 8'h01);
                    end
                    if (start_run) begin
                        mix_q    <= 1'b1;
                        lay_q    <= '0;
                        placed_q <= '0;
                        tries_q  <= '0;
                    end
                end
                S_DRAW: begin
                    cand_x_q <= draw_x;
                    cand_y_q <= draw_y;
                    cmp_q    <= '0;
                end
                S_CHECK: begin
                    if (!cmp_done) begin
                        if (reject) tries_q <= tries_q + 1'b1;
                        else        cmp_q   <= cmp_q + 1'b1;
                    end
                end
                S_COMMIT: begin
                    pos_x[lay_q]    <= cand_x_q;
                    pos_y[lay_q]    <= cand_y_q;
                    placed_q[lay_q] <= 1'b1;
                end
                S_NEXT: begin
                    tries_q <= '0;
                    if (lay_q != LAST_LAYER) lay_q <= lay_q + 1'b1;
                end
                S_DONE: begin
                    show_q <= FIELD_W'(placed_q);
                    cnt_q  <= FIELD_W'(NUM_LAYERS - 1);
                    mix_q  <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy        = (state_q != S_IDLE);
        csr_rd_data = {busy, 7'b0, show_q, cnt_q, 7'b0, mix_q};
        layer_en_o  = busy ? '0 : show_q[NUM_LAYERS-1:0];
    end

    for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_pos
        assign layer_x_o[g*XW +: XW] = pos_x[g];
        assign layer_y_o[g*YW +: YW] = pos_y[g];
    end

    // ---------------- assertions ----------------
    // R4: empty mask while idle starts a run on the next clock
    p_empty_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && show_q == '0) |=> (state_q == S_DRAW));

    // R6: the final step clears the request and fills in the count
    p_done_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE) |=> (!mix_q && cnt_q == FIELD_W'(NUM_LAYERS - 1)));

    // R7: every committed candidate lies inside the frame
    p_cand_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COMMIT) |-> (int'(cand_x_q) <= FRAME_W - MARK_SZ &&
                                   int'(cand_y_q) <= FRAME_H - MARK_SZ));

    // R8: the show mask holds through a run until the write-back
    p_mask_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && state_q != S_DONE) |=> $stable(show_q));

    // R9: offsets never move out of a run
    p_pos_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |=> ($stable(layer_x_o) && $stable(layer_y_o)));

    // R10: the attempt counter never reaches the limit
    p_tries_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHECK) |-> (tries_q < TW'(MAX_TRIES)));

endmodule

// File: tb/fid_place_ctrl_bench.sv
module fid_place_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 5;
    localparam int MSZ        = 64;
    localparam int FW         = 960;
    localparam int FH         = 540;
    localparam int XW         = $clog2(FW);
    localparam int YW         = $clog2(FH);
    localparam int RUN_LIMIT  = N * (64 * (N + 2) + 3) + 4;
    localparam logic [7:0] FULL = 8'h1F;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               csr_wr_en = 1'b0;
    logic [31:0]        csr_wr_data = '0;
    logic [31:0]        csr_rd_data;
    logic [N-1:0]       layer_en_o;
    logic [N*XW-1:0]    layer_x_o;
    logic [N*YW-1:0]    layer_y_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    // behavioural model state
    bit         m_busy = 1'b0;
    logic [7:0] m_show = '0;
    logic [7:0] m_cnt  = '0;
    bit         m_mix  = 1'b0;
    int         run_cycles = 0;
    logic [N*XW-1:0] snap_x = '0;
    logic [N*YW-1:0] snap_y = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fid_place_ctrl u_fid_place_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .csr_wr_en   (csr_wr_en),
        .csr_wr_data (csr_wr_data),
        .csr_rd_data (csr_rd_data),
        .layer_en_o  (layer_en_o),
        .layer_x_o   (layer_x_o),
        .layer_y_o   (layer_y_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int px(input int i);
        return int'(layer_x_o[i*XW +: XW]);
    endfunction

    function automatic int py(input int i);
        return int'(layer_y_o[i*YW +: YW]);
    endfunction

    task automatic check_layout();
        for (int i = 0; i < N; i++) begin
            chk(px(i) <= FW - MSZ, "R7", "x inside frame", px(i), FW - MSZ);
            chk(py(i) <= FH - MSZ, "R7", "y inside frame", py(i), FH - MSZ);
            for (int j = i + 1; j < N; j++) begin
                int dx = (px(i) > px(j)) ? px(i) - px(j) : px(j) - px(i);
                int dy = (py(i) > py(j)) ? py(i) - py(j) : py(j) - py(i);
                chk(dx >= MSZ || dy >= MSZ, "R7", "pair separated",
                    {32'(dx), 32'(dy)}, MSZ);
            end
        end
    endtask

    // model: start conditions and accepted writes, evaluated at the capture edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_show = '0; m_cnt = '0; m_mix = 1'b0;
        end else if (!m_busy) begin
            bit go;
            go = m_mix || (m_show == 8'h00);
            if (csr_wr_en) begin
                m_show = csr_wr_data[23:16] & FULL;
                m_mix  = (csr_wr_data[7:0] == 8'h01);
            end
            if (go) begin
                m_busy = 1'b1; m_mix = 1'b1; run_cycles = 0;
            end
        end
    end

    // per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (m_busy && !csr_rd_data[31]) begin
                m_busy = 1'b0; m_show = FULL; m_cnt = 8'(N - 1); m_mix = 1'b0;
                chk(csr_rd_data[23:16] == FULL, "R6", "mask after run",
                    csr_rd_data[23:16], FULL);
                check_layout();
                snap_x = layer_x_o;
                snap_y = layer_y_o;
            end
            if (m_busy) begin
                run_cycles++;
                if (run_cycles == RUN_LIMIT + 1)
                    chk(1'b0, "R10", "run length", run_cycles, RUN_LIMIT);
            end
            chk(csr_rd_data == {m_busy, 7'b0, m_show, m_cnt, 7'b0, m_mix}, "R2",
                "read word", csr_rd_data, {m_busy, 7'b0, m_show, m_cnt, 7'b0, m_mix});
            chk(layer_en_o == (m_busy ? '0 : m_show[N-1:0]), "R9", "enables",
                layer_en_o, m_busy ? '0 : m_show[N-1:0]);
            if (!m_busy)
                chk(layer_x_o == snap_x && layer_y_o == snap_y, "R5", "offsets frozen",
                    {layer_x_o, layer_y_o}, {snap_x, snap_y});
        end
    end

    task automatic csr_write(input logic [31:0] d);
        @(negedge clk);
        csr_wr_en   = 1'b1;
        csr_wr_data = d;
        @(negedge clk);
        csr_wr_en   = 1'b0;
        csr_wr_data = '0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (csr_rd_data[31] && guard < RUN_LIMIT + 10);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "R10", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(csr_rd_data == 32'h0, "R1", "read word in reset", csr_rd_data, 0);
        chk(layer_en_o == '0, "R1", "enables in reset", layer_en_o, 0);
        chk(layer_x_o == '0 && layer_y_o == '0, "R1", "offsets in reset",
            {layer_x_o, layer_y_o}, 0);
        rst_n = 1'b1;

        // R4: empty mask after reset starts a run one clock later
        @(negedge clk);
        chk(csr_rd_data[31] == 1'b1, "R4", "busy after reset", csr_rd_data[31], 1);
        chk(csr_rd_data[7:0] == 8'h01, "R4", "mix during auto run", csr_rd_data[7:0], 1);
        wait_idle();
        chk(csr_rd_data == {8'h00, FULL, 8'(N - 1), 8'h00}, "R6", "word after run",
            csr_rd_data, {8'h00, FULL, 8'(N - 1), 8'h00});

        // R5: selective show, no run
        csr_write(32'h0011_0000);
        chk(layer_en_o == 5'h11, "R5", "subset enables", layer_en_o, 5'h11);
        repeat (3) @(negedge clk);
        chk(csr_rd_data[31] == 1'b0, "R5", "no run on subset", csr_rd_data[31], 0);

        // R2, R3, R11: count not writable, bad request value, high mask bits
        csr_write(32'h0077_FF05);
        chk(csr_rd_data == {8'h00, 8'h17, 8'(N - 1), 8'h00}, "R11", "masked write",
            csr_rd_data, {8'h00, 8'h17, 8'(N - 1), 8'h00});
        @(negedge clk);
        chk(csr_rd_data[31] == 1'b0, "R3", "non-0x01 request starts nothing",
            csr_rd_data[31], 0);

        // R3: explicit request
        csr_write(32'h0004_0001);
        chk(csr_rd_data[31] == 1'b0 && csr_rd_data[7:0] == 8'h01, "R3",
            "request held before start", csr_rd_data, 32'h0004_0401);
        @(negedge clk);
        chk(csr_rd_data[31] == 1'b1, "R3", "busy two clocks after write",
            csr_rd_data[31], 1);

        // R8: write during the run is ignored
        csr_write(32'h0002_0000);
        chk(csr_rd_data[23:16] == 8'h04, "R8", "mask frozen in run",
            csr_rd_data[23:16], 8'h04);
        wait_idle();
        chk(csr_rd_data[23:16] == FULL, "R8", "busy write discarded",
            csr_rd_data[23:16], FULL);

        // R4: pick-and-clear loop, last clear reshuffles
        for (int k = 1; k <= N; k++) begin
            csr_write({8'h00, FULL & (FULL << k), 16'h0000});
        end
        chk(csr_rd_data[31] == 1'b0 && csr_rd_data[23:16] == 8'h00, "R4",
            "mask empty after last pick", csr_rd_data, 0);
        @(negedge clk);
        chk(csr_rd_data[31] == 1'b1, "R4", "auto run after last pick",
            csr_rd_data[31], 1);
        wait_idle();
        chk(csr_rd_data[23:16] == FULL && layer_en_o == FULL[N-1:0], "R6",
            "refilled after reshuffle", {csr_rd_data[23:16], 3'b0, layer_en_o},
            {FULL, 3'b0, FULL[N-1:0]});

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule